// File: doc/BRIEF.md
# Non-Volatile Word Programming Window

This block gives a host a small byte-wide register window for reading and writing 16-bit words in an on-chip non-volatile store. The host writes a 9-bit word address and a data word into byte registers. It then writes a command byte that carries an opcode and a go-ahead flag. After that it polls a status bit until the operation finishes. A read operation copies the addressed word into the two data byte registers, where the host can collect it afterwards.

The window responds only while the `cfg_mode` input shows that the card is in its configuration state. Outside that state, bus writes have no effect and bus reads return zero. A store write is slow: it keeps the block busy for `WR_CYCLES` clocks, a parameter that defaults to roughly 10 ms at a 14.318 MHz clock. A store read keeps the block busy for `RD_CYCLES` clocks. The storage array is a simple internal model.

Register offsets that the host uses: 0xF0 command, 0xF1 address low byte, 0xF2 data high byte, 0xF3 data low byte, 0x05 status.

Top module: `eeprom_win`

## Requirements
- R1: After reset, registers 0xF0 to 0xF3 read 0x00, and status register 0x05 reads 0x01 (idle and done).
- R2: While `cfg_mode` is 0, bus writes change no register and bus reads return 0x00.
- R3: The command byte at 0xF0 holds the opcode in bits 1:0, the go-ahead flag in bit 2 and word address bit 8 in bit 7. Bits 6:3 always read 0, whatever was written to them.
- R4: Writing 0xF0 with opcode 01 and bit 2 set starts a store write. Status bit 0 reads 0 for exactly `WR_CYCLES` clocks and then reads 1. At that point the word {0xF2, 0xF3} is stored at address {0xF0 bit 7, 0xF1}.
- R5: Writing 0xF0 with opcode 10 and bit 2 set starts a store read. Status bit 0 reads 0 for exactly `RD_CYCLES` clocks. By the time it reads 1, 0xF2 holds the word's high byte and 0xF3 holds its low byte.
- R6: The go-ahead bit (0xF0 bit 2) reads 0 once an operation has completed.
- R7: Writing 0xF0 with bit 2 set and opcode 00 or 11 starts nothing. Status stays 1, and the command byte reads back with bit 2 clear.
- R8: While status bit 0 reads 0, bus writes to 0xF0 to 0xF3 are ignored.
- R9: In status register 0x05, bits 7:1 read 0. Any address outside 0x05 and 0xF0 to 0xF3 reads 0x00.
- R10: Word address bit 8 selects a separate half of the store. Words that share the same low address byte but differ in bit 8 are kept apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | High while the card is in the configuration state |
| bus_wr | input | 1 | Register write strobe, one clock wide |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data byte, combinational, 0 when no read is active |

## Verification
A busy counter that is wrong shows up on the very next status poll. The done bit then comes back one or more clocks too early or too late compared with the reference model. A wrong address or data path stays hidden until the later read of that word: there, the data bytes differ from what the model expects. A go-ahead flag or reserved bit that should have cleared, but did not, shows at the next read of the command byte. Because the model is compared against `bus_rdata` on every clock, a write that should have been ignored while busy or outside the configuration state shows up on the next read of that register.

// File: rtl/eeprom_win_pkg.sv
package eeprom_win_pkg;

   typedef enum logic [1:0] {
      OP_NONE  = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_BAD   = 2'b11
   } win_op_e;

   localparam logic [7:0] OFS_STAT = 8'h05;
   localparam logic [7:0] OFS_CMD  = 8'hF0;
   localparam logic [7:0] OFS_ADR  = 8'hF1;
   localparam logic [7:0] OFS_DHI  = 8'hF2;
   localparam logic [7:0] OFS_DLO  = 8'hF3;

   localparam int CMD_GO_BIT = 2;

endpackage

// File: rtl/eeprom_win_seq.sv
module eeprom_win_seq #(
   parameter int WR_CYCLES = 16,
   parameter int RD_CYCLES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic start_wr,
   output logic busy,
   output logic fin,
   output logic fin_wr
);
   localparam int MAXC = (WR_CYCLES > RD_CYCLES) ? WR_CYCLES : RD_CYCLES;
   localparam int CW   = $clog2(MAXC + 1);

   if (WR_CYCLES < 1) begin : g_bad_wr
      $error("eeprom_win_seq: WR_CYCLES must be at least 1");
   end
   if (RD_CYCLES < 1) begin : g_bad_rd
      $error("eeprom_win_seq: RD_CYCLES must be at least 1");
   end

   logic [CW-1:0] cnt_q;
   logic          busy_q;
   logic          wr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         busy_q <= 1'b0;
         wr_q   <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         wr_q   <= start_wr;
         cnt_q  <= start_wr ? CW'(WR_CYCLES - 1) : CW'(RD_CYCLES - 1);
      end else if (fin) begin
         busy_q <= 1'b0;
      end else if (busy_q) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy   = busy_q;
   assign fin    = busy_q && (cnt_q == '0);
   assign fin_wr = wr_q;

   a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> !busy_q)
      else $error("R8: launch accepted while busy");

   a_r4_ends_idle: assert property (@(posedge clk) disable iff (!rst_n)
      fin && !start |=> !busy_q)
      else $error("R4: busy held past completion");

endmodule

// File: rtl/eeprom_win_store.sv
module eeprom_win_store #(
   parameter int AW = 9,
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   if (AW < 1 || AW > 12) begin : g_bad_aw
      $error("eeprom_win_store: AW out of range");
   end

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[addr] <= wdata;
   end

   assign rdata = mem[addr];

   a_r4_commit: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr)] == $past(wdata))
      else $error("R4: word not committed");

endmodule

// File: rtl/eeprom_win_regs.sv
module eeprom_win_regs
   import eeprom_win_pkg::*;
#(
   parameter int AW = 9,
   parameter int DW = 16,
   parameter int BW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mode,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [BW-1:0] bus_addr,
   input  logic [BW-1:0] bus_wdata,
   output logic [BW-1:0] bus_rdata,
   input  logic          busy,
   input  logic          fin,
   input  logic          fin_wr,
   input  logic [DW-1:0] rd_word,
   output logic          start,
   output logic          start_wr,
   output logic [AW-1:0] word_addr,
   output logic [DW-1:0] wr_word
);
   if (DW != 2 * BW || AW != BW + 1 || BW != 8) begin : g_bad_geom
      $error("eeprom_win_regs: needs BW=8, DW=2*BW, AW=BW+1");
   end

   win_op_e       op_q;
   logic          go_q;
   logic          a8_q;
   logic [BW-1:0] lo_q, dhi_q, dlo_q;

   logic    acc_wr;
   win_op_e new_op;
   logic    op_ok;

   assign acc_wr   = cfg_mode && bus_wr && !busy;
   assign new_op   = win_op_e'(bus_wdata[1:0]);
   assign op_ok    = (new_op == OP_WRITE) || (new_op == OP_READ);
   assign start    = acc_wr && (bus_addr == OFS_CMD) && bus_wdata[CMD_GO_BIT] && op_ok;
   assign start_wr = (new_op == OP_WRITE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         op_q  <= OP_NONE;
         go_q  <= 1'b0;
         a8_q  <= 1'b0;
         lo_q  <= '0;
         dhi_q <= '0;
         dlo_q <= '0;
      end else begin
         if (fin) begin
            go_q <= 1'b0;
            if (!fin_wr) {dhi_q, dlo_q} <= rd_word;
         end
         if (acc_wr) begin
            case (bus_addr)
               OFS_CMD: begin
                  op_q <= new_op;
                  a8_q <= bus_wdata[BW-1];
                  go_q <= start;
               end
               OFS_ADR: lo_q  <= bus_wdata;
               OFS_DHI: dhi_q <= bus_wdata;
               OFS_DLO: dlo_q <= bus_wdata;
               default: ;
            endcase
         end
      end
   end

   assign word_addr = {a8_q, lo_q};
   assign wr_word   = {dhi_q, dlo_q};

   always_comb begin
      bus_rdata = '0;
      if (cfg_mode && bus_rd) begin
         case (bus_addr)
            OFS_CMD:  bus_rdata = {a8_q, 4'b0000, go_q, op_q};
            OFS_ADR:  bus_rdata = lo_q;
            OFS_DHI:  bus_rdata = dhi_q;
            OFS_DLO:  bus_rdata = dlo_q;
            OFS_STAT: bus_rdata = {{(BW-1){1'b0}}, !busy};
            default:  bus_rdata = '0;
         endcase
      end
   end

   a_r6_go_clears: assert property (@(posedge clk) disable iff (!rst_n)
      fin |=> !go_q)
      else $error("R6: go-ahead still set after completion");

   a_r5_read_loads: assert property (@(posedge clk) disable iff (!rst_n)
      fin && !fin_wr |=> {dhi_q, dlo_q} == $past(rd_word))
      else $error("R5: data bytes not loaded from store");

   a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(lo_q) && $stable(a8_q) && $stable(op_q))
      else $error("R8: register changed while busy");

   a_r7_bad_op: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_wr && bus_addr == OFS_CMD && bus_wdata[CMD_GO_BIT] && !op_ok) |=> !go_q && !busy)
      else $error("R7: invalid opcode launched an operation");

   a_r2_closed: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_mode && !busy |=> $stable(lo_q) && $stable(op_q) && $stable(dhi_q))
      else $error("R2: register changed outside configuration state");

endmodule

// File: rtl/eeprom_win.sv
module eeprom_win #(
   parameter int WR_CYCLES = 143180,
   parameter int RD_CYCLES = 2,
   parameter int AW        = 9,
   parameter int DW        = 16,
   parameter int BW        = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_mode,
   input  logic          bus_wr,
   input  logic          bus_rd,
   input  logic [BW-1:0] bus_addr,
   input  logic [BW-1:0] bus_wdata,
   output logic [BW-1:0] bus_rdata
);
   logic          start, start_wr, busy, fin, fin_wr;
   logic [AW-1:0] word_addr;
   logic [DW-1:0] wr_word, rd_word;

   eeprom_win_regs #(.AW(AW), .DW(DW), .BW(BW)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .busy(busy), .fin(fin), .fin_wr(fin_wr), .rd_word(rd_word),
      .start(start), .start_wr(start_wr),
      .word_addr(word_addr), .wr_word(wr_word)
   );

   eeprom_win_seq #(.WR_CYCLES(WR_CYCLES), .RD_CYCLES(RD_CYCLES)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .start_wr(start_wr),
      .busy(busy), .fin(fin), .fin_wr(fin_wr)
   );

   eeprom_win_store #(.AW(AW), .DW(DW)) u_store (
      .clk(clk), .rst_n(rst_n), .we(fin && fin_wr),
      .addr(word_addr), .wdata(wr_word), .rdata(rd_word)
   );

endmodule

// File: tb/eeprom_win_bench.sv
module eeprom_win_bench;
   localparam int CLK_NS = 10;
   localparam int WR_C   = 12;
   localparam int RD_C   = 3;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_mode = 1'b1;
   logic       bus_wr = 1'b0;
   logic       bus_rd = 1'b0;
   logic [7:0] bus_addr = 8'h00;
   logic [7:0] bus_wdata = 8'h00;
   logic [7:0] bus_rdata;

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   eeprom_win #(.WR_CYCLES(WR_C), .RD_CYCLES(RD_C)) u_eeprom_win (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
   );

   always #(CLK_NS/2) clk = ~clk;

   // behavioural reference model
   int m_op, m_go, m_a8, m_lo, m_dhi, m_dlo, m_left, m_pwr;
   int m_mem [int];

   function automatic int model_read(int a);
      if (!cfg_mode || !bus_rd) return 0;
      case (a)
         'hF0: return (m_a8 << 7) | (m_go << 2) | m_op;
         'hF1: return m_lo;
         'hF2: return m_dhi;
         'hF3: return m_dlo;
         'h05: return (m_left == 0) ? 1 : 0;
         default: return 0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_op = 0; m_go = 0; m_a8 = 0; m_lo = 0; m_dhi = 0; m_dlo = 0;
         m_left = 0; m_pwr = 0;
      end else if (m_left > 0) begin
         m_left--;
         if (m_left == 0) begin
            int wa;
            wa = m_a8 * 256 + m_lo;
            m_go = 0;
            if (m_pwr != 0) m_mem[wa] = m_dhi * 256 + m_dlo;
            else if (m_mem.exists(wa)) begin
               m_dhi = m_mem[wa] / 256;
               m_dlo = m_mem[wa] % 256;
            end
         end
      end else if (cfg_mode && bus_wr) begin
         case (int'(bus_addr))
            'hF0: begin
               m_op = bus_wdata[1:0];
               m_a8 = bus_wdata[7];
               if (bus_wdata[2] && (m_op == 1 || m_op == 2)) begin
                  m_go = 1;
                  m_pwr = (m_op == 1);
                  m_left = (m_op == 1) ? WR_C : RD_C;
               end else m_go = 0;
            end
            'hF1: m_lo = bus_wdata;
            'hF2: m_dhi = bus_wdata;
            'hF3: m_dlo = bus_wdata;
            default: ;
         endcase
      end
   end

   task automatic cyc(input bit w, input bit r, input int a, input int d, input string req);
      int ex;
      @(negedge clk);
      bus_wr = w; bus_rd = r; bus_addr = a[7:0]; bus_wdata = d[7:0];
      #1;
      ex = model_read(a);
      vectors++;
      if (bus_rdata !== ex[7:0]) begin
         miscompares++;
         $display("FAIL %s addr=%h rdata=%h expected %h", req, a[7:0], bus_rdata, ex[7:0]);
      end
   endtask

   task automatic wr(input int a, input int d, input string req);
      cyc(1, 0, a, d, req);
   endtask

   task automatic rd(input int a, input string req);
      cyc(0, 1, a, 0, req);
   endtask

   task automatic poll(input string req);
      do rd('h05, req); while (m_left > 0);
      rd('h05, req);
   endtask

   task automatic put_word(input int wa, input int val, input string req);
      wr('hF1, wa % 256, req);
      wr('hF2, val / 256, req);
      wr('hF3, val % 256, req);
      wr('hF0, ((wa / 256) << 7) | 8'h05, req);
      poll(req);
   endtask

   task automatic get_word(input int wa, input string req);
      wr('hF2, 0, req);
      wr('hF3, 0, req);
      wr('hF1, wa % 256, req);
      wr('hF0, ((wa / 256) << 7) | 8'h06, req);
      poll(req);
      rd('hF2, req);
      rd('hF3, req);
      rd('hF0, req);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset values, R9 status and unmapped
      rd('hF0, "R1"); rd('hF1, "R1"); rd('hF2, "R1"); rd('hF3, "R1");
      rd('h05, "R1"); rd('h05, "R9"); rd('h40, "R9"); rd('hF4, "R9");

      // R2 closed window
      cfg_mode = 1'b0;
      wr('hF1, 'h55, "R2"); wr('hF0, 'h86, "R2"); rd('hF1, "R2"); rd('h05, "R2");
      cfg_mode = 1'b1;
      rd('hF1, "R2"); rd('hF0, "R2"); rd('h05, "R2");

      // R3 reserved bits and field positions
      wr('hF0, 'hF8, "R3"); rd('hF0, "R3");
      wr('hF0, 'h7B, "R3"); rd('hF0, "R3");

      // R4 write with R8 ignored writes while busy, R6 go clears
      wr('hF1, 'h12, "R4"); wr('hF2, 'hAB, "R4"); wr('hF3, 'hCD, "R4");
      wr('hF0, 'h85, "R4");
      rd('h05, "R4"); rd('hF0, "R6");
      wr('hF2, 'h00, "R8"); wr('hF1, 'h77, "R8"); wr('hF0, 'h06, "R8");
      rd('hF2, "R8"); rd('hF1, "R8"); rd('hF0, "R8");
      poll("R4");
      rd('hF0, "R6");

      // R10 same low byte, other half
      put_word('h012, 'h1234, "R10");

      // R5 read back both halves
      get_word('h112, "R5");
      get_word('h012, "R10");

      // R7 invalid opcodes with go
      wr('hF0, 'h87, "R7"); rd('hF0, "R7"); rd('h05, "R7");
      wr('hF0, 'h04, "R7"); rd('hF0, "R7"); rd('h05, "R7");

      // further patterns
      begin
         int seed;
         seed = 32'h1F2E3D4C;
         for (int i = 0; i < 8; i++) begin
            int wa, val;
            seed = seed * 1103515245 + 12345;
            wa  = (seed >>> 8) & 'h1FF;
            val = (seed >>> 12) & 'hFFFF;
            put_word(wa, val, "R4");
            get_word(wa, "R5");
         end
      end
      put_word('h1FF, 'hFFFF, "R4");
      put_word('h000, 'h0000, "R4");
      get_word('h1FF, "R10");
      get_word('h000, "R10");

      @(negedge clk);
      bus_wr = 1'b0; bus_rd = 1'b0;
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      #(CLK_NS * 150000);
      if (!finished) begin
         miscompares++;
         $display("FAIL watchdog: run did not complete, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule